// File: doc/BRIEF.md
# Character-Row Video Timing Controller

This block generates the raster timing for a character-based display. One character position passes on every clock. A horizontal counter steps through the characters of a scanline. A scanline counter steps through the lines of one character row. A row counter steps through the rows of a frame. At frame end, a programmable number of extra scanlines can be added. From these counters the block derives horizontal and vertical sync, a border flag, a 14-bit memory address and a 5-bit row address. A downstream memory fetch uses the two addresses to find the glyph or bitmap data.

Software programs sixteen 8-bit timing registers through one narrow port. One access sets the register index. The next access loads data into the register that index selects. The port has no direction input, so every access stores the data bus. At the end of the block, a colour merge combines the pixel value, the border colour and sync-time black into a single colour output.

The frame start address is copied from its registers only at the frame boundary. The base address of each following character row comes from the memory address saved on the scanline before the row's last one. Clearing the displayed-row count forces the border over the whole screen.

Top module: `char_raster_timer`

## Requirements
- R1: A scanline lasts R0+1 clocks, because the horizontal count runs 0..R0. A frame lasts (R4+1)*(R9+1)+R5 scanlines, where R4 is the last row index, R9 the last scanline index in a row, and R5 the extra scanlines at frame end.
- R2: `border` is low only while the horizontal count is below R1, the row count is below R6, and the extra frame-end scanlines are not running. When R6 is 0, `border` stays high on every cycle.
- R3: `hsync` rises on the clock whose horizontal count equals R2. It stays high for R3[3:0] clocks, and a value of 0 there means 16 clocks.
- R4: At each frame start, the row base is loaded with the 14-bit start address {R12[5:0], R13}. Writes to R12 or R13 during a frame do not change the addresses of that frame. The new value first shows in `ma` on the first clock of the next frame.
- R5: `vsync` rises on the clock where the horizontal count is 0, the scanline count is 0 and the row count equals R7. It then stays high for 16 scanlines. `ra` is 0 at that rise.
- R6: `ma` equals the row base plus the horizontal count, so it rises by one on every clock within a scanline. `ra` shows the scanline count. At horizontal count R1 on scanline R9-1 (scanline 0 when R9 is 0), `ma` is saved. The saved value becomes the row base of the next character row.
- R7: `colour_out` is 0 while `hsync` or `vsync` is high. Otherwise it is `bord_col` while `border` is high, and `pix_in` the rest of the time.
- R8: A cycle with `acc_en` high and `acc_port` 0 loads `acc_din[3:0]` as the register index. A cycle with `acc_en` high and `acc_port` 1 stores `acc_din` into the indexed register. Both are writes whatever the bus direction. `acc_dout` shows the indexed register for indices 12 and 13 and is 0 for every other index.
- R9: While `rst_n` is low, all registers, counters and the index are 0. The outputs are then `ma`=0, `ra`=0, `border`=1, `hsync`=1, `vsync`=1, `colour_out`=0 and `acc_dout`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Register port access strobe |
| acc_port | input | 1 | 0 selects the index port, 1 the data port |
| acc_din | input | 8 | Register port data bus |
| acc_dout | output | 8 | Readback of indexed register (zero if write-only) |
| pix_in | input | COL_W | Pixel colour from the fetch stage |
| bord_col | input | COL_W | Border colour |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| border | output | 1 | High outside the displayed area |
| ma | output | 14 | Memory address |
| ra | output | 5 | Row (scanline) address |
| colour_out | output | COL_W | Merged colour output |

## Verification
The assertions check these properties on every cycle:
- `hsync` rises only at the programmed horizontal position.
- `vsync` rises only on the first clock of a row's first scanline.
- `ma` steps by exactly one inside a scanline, and the row base never moves mid-line.
- `border` holds while R6 is 0.

Only the bench scenarios can show frame and line periods, pulse widths, and the start address taking effect at the next frame rather than the current one. The same holds for the saved row base of the second row and the colour priority under real pixel and border values.

// File: rtl/char_raster_timer.sv
module char_raster_timer #(
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_port,
  input  logic [7:0]       acc_din,
  output logic [7:0]       acc_dout,
  input  logic [COL_W-1:0] pix_in,
  input  logic [COL_W-1:0] bord_col,
  output logic             hsync,
  output logic             vsync,
  output logic             border,
  output logic [13:0]      ma,
  output logic [4:0]       ra,
  output logic [COL_W-1:0] colour_out
);
  localparam int NREG = 16;
  localparam int MA_W = 14;

  logic [7:0]      regs [NREG];
  logic [3:0]      idx;
  logic [7:0]      hcnt;
  logic [6:0]      row;
  logic [4:0]      rc;
  logic            in_adj;
  logic [MA_W-1:0] row_base, next_base;
  logic [3:0]      hs_cnt;
  logic [4:0]      vs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (acc_en) begin
      if (!acc_port) idx <= acc_din[3:0];
      else           regs[idx] <= acc_din;
    end
  end

  assign acc_dout = (idx == 4'd12 || idx == 4'd13) ? regs[idx] : 8'h00;

  logic            line_end, row_last_line, last_row, adj_last, frame_end;
  logic [4:0]      cap_rc;
  logic [MA_W-1:0] start_addr;

  assign line_end      = hcnt >= regs[0];
  assign row_last_line = rc >= regs[9][4:0];
  assign last_row      = row >= regs[4][6:0];
  assign adj_last      = rc >= (regs[5][4:0] - 5'd1);
  assign frame_end     = line_end && (in_adj ? adj_last
                         : (row_last_line && last_row && regs[5][4:0] == 5'd0));
  assign start_addr    = {regs[12][5:0], regs[13]};
  assign cap_rc        = (regs[9][4:0] == 5'd0) ? 5'd0 : regs[9][4:0] - 5'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0; row <= '0; rc <= '0; in_adj <= 1'b0;
      row_base <= '0; next_base <= '0;
    end else begin
      hcnt <= line_end ? 8'd0 : hcnt + 8'd1;
      if (hcnt == regs[1] && rc == cap_rc && !in_adj) next_base <= ma;
      if (line_end) begin
        if (frame_end) begin
          row <= '0; rc <= '0; in_adj <= 1'b0;
          row_base <= start_addr; next_base <= start_addr;
        end else if (in_adj) begin
          rc <= rc + 5'd1;
        end else if (row_last_line) begin
          rc <= '0;
          if (last_row) in_adj <= 1'b1;
          else begin
            row <= row + 7'd1;
            row_base <= next_base;
          end
        end else begin
          rc <= rc + 5'd1;
        end
      end
    end
  end

  assign ma = row_base + {6'd0, hcnt};
  assign ra = rc;

  logic hs_go, vs_go;
  assign hs_go = (hcnt == regs[2]) && (hs_cnt == 4'd0);
  assign hsync = hs_go || (hs_cnt != 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 hs_cnt <= '0;
    else if (hs_go)             hs_cnt <= regs[3][3:0] - 4'd1;
    else if (hs_cnt != 4'd0)    hs_cnt <= hs_cnt - 4'd1;
  end

  assign vs_go = (hcnt == 8'd0) && (row == regs[7][6:0]) && (rc == 5'd0)
                 && !in_adj && (vs_cnt == 5'd0);
  assign vsync = vs_go || (vs_cnt != 5'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)                            vs_cnt <= '0;
    else if (vs_go)                        vs_cnt <= line_end ? 5'd15 : 5'd16;
    else if (line_end && vs_cnt != 5'd0)   vs_cnt <= vs_cnt - 5'd1;
  end

  assign border = !((hcnt < regs[1]) && !in_adj && (row < regs[6][6:0]));

  assign colour_out = (hsync || vsync) ? '0 : (border ? bord_col : pix_in);

  a_r3_hs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> hcnt == regs[2]);

  a_r5_vs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (hcnt == 8'd0 && ra == 5'd0));

  a_r6_ma_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(line_end)) |-> ma == $past(ma) + 14'd1);

  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(line_end)) |-> $stable(row_base));

  a_r2_forced_border: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[6] == 8'd0) |-> border);
endmodule

// File: tb/char_raster_timer_test.sv
`timescale 1ns/1ps
module char_raster_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0, acc_port = 1'b0;
  logic [7:0] acc_din = 8'h00, acc_dout;
  logic [5:0] pix_in = 6'd5, bord_col = 6'd9, colour_out;
  logic       hsync, vsync, border;
  logic [13:0] ma;
  logic [4:0] ra;

  char_raster_timer #(.COL_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_port(acc_port),
    .acc_din(acc_din), .acc_dout(acc_dout), .pix_in(pix_in), .bord_col(bord_col),
    .hsync(hsync), .vsync(vsync), .border(border), .ma(ma), .ra(ra),
    .colour_out(colour_out));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0]  r0, r2, r3, r4, r5, r9, r7;
    logic [15:0] e_line, e_hsw, e_frame, e_vsw, e_hpos;
  } cfg_t;

  localparam cfg_t CFGS [3] = '{
    '{8'd24, 8'd5,  8'd0, 8'd8, 8'd0,  8'd1, 8'd1, 16'd25, 16'd16, 16'd450, 16'd400, 16'd5},
    '{8'd15, 8'd10, 8'd1, 8'd0, 8'd20, 8'd0, 8'd0, 16'd16, 16'd1,  16'd336, 16'd256, 16'd10},
    '{8'd19, 8'd14, 8'd4, 8'd5, 8'd2,  8'd3, 8'd2, 16'd20, 16'd4,  16'd520, 16'd320, 16'd14}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input bit port, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_port = port; acc_din = d;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic write_reg(input logic [3:0] i, input logic [7:0] d);
    access(1'b0, {4'd0, i});
    access(1'b1, d);
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic wait_rise(input bit which, output int t);
    bit prev, cur, hit;
    int n;
    prev = which ? vsync : hsync;
    hit = 1'b0; n = 0;
    while (!hit && n < 4000) begin
      @(negedge clk);
      cur = which ? vsync : hsync;
      if (cur && !prev) hit = 1'b1;
      prev = cur; n++;
    end
    if (!hit) check(which ? "R5 vsync edge timeout" : "R3 hsync edge timeout", 0, 1);
    t = cyc;
  endtask

  task automatic high_len(input bit which, output int w);
    w = 0;
    while ((which ? vsync : hsync) && w < 5000) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    int t0, t1, th, th2, w, f, cnt;
    repeat (3) @(negedge clk);
    check("R9 reset ma", ma, 0);
    check("R9 reset ra", ra, 0);
    check("R9 reset border", border, 1);
    check("R9 reset hsync", hsync, 1);
    check("R9 reset vsync", vsync, 1);
    check("R9 reset colour", colour_out, 0);
    check("R9 reset dout", acc_dout, 0);
    rst_n = 1'b1;

    write_reg(4'd12, 8'h2A);
    @(negedge clk);
    check("R8 readback idx12", acc_dout, 8'h2A);
    access(1'b0, 8'd3);
    check("R8 write-only idx3 reads zero", acc_dout, 0);
    access(1'b0, 8'd13);
    access(1'b1, 8'h77);
    check("R8 data-port cycle stores bus", acc_dout, 8'h77);

    write_reg(4'd1, 8'd12);
    write_reg(4'd6, 8'd4);
    write_reg(4'd12, 8'h01);
    write_reg(4'd13, 8'h00);

    for (int k = 0; k < 3; k++) begin
      write_reg(4'd0, CFGS[k].r0);
      write_reg(4'd2, CFGS[k].r2);
      write_reg(4'd3, CFGS[k].r3);
      write_reg(4'd4, CFGS[k].r4);
      write_reg(4'd5, CFGS[k].r5);
      write_reg(4'd9, CFGS[k].r9);
      write_reg(4'd7, CFGS[k].r7);
      wait_rise(1'b1, t0);
      wait_rise(1'b1, t0);
      high_len(1'b1, w);
      check($sformatf("R5 vsync width cfg%0d", k), w, CFGS[k].e_vsw);
      wait_rise(1'b1, t1);
      check($sformatf("R1 frame period cfg%0d", k), t1 - t0, CFGS[k].e_frame);
      check($sformatf("R5 ra at vsync cfg%0d", k), ra, 0);
      wait_rise(1'b0, th);
      check($sformatf("R3 hsync position cfg%0d", k), th - t1, CFGS[k].e_hpos);
      high_len(1'b0, w);
      check($sformatf("R3 hsync width cfg%0d", k), w, CFGS[k].e_hsw);
      wait_rise(1'b0, th2);
      check($sformatf("R1 line period cfg%0d", k), th2 - th, CFGS[k].e_line);
    end

    wait_rise(1'b1, t0);
    f = t0 - 160 + 520;
    wait_until(f);
    check("R4 frame start ma", ma, 14'h100);
    check("R4 frame start ra", ra, 0);
    check("R2 display inside", border, 0);
    wait_until(f + 3);
    check("R7 pixel shown", colour_out, 5);
    wait_until(f + 7);
    check("R6 ma increments", ma, 14'h107);
    wait_until(f + 12);
    check("R2 border at R1", border, 1);
    check("R7 border colour", colour_out, 9);
    wait_until(f + 14);
    check("R7 hsync black", colour_out, 0);
    wait_until(f + 20);
    write_reg(4'd12, 8'h02);
    wait_until(f + 80);
    check("R6 saved row base", ma, 14'h10C);
    check("R4 no mid-frame change", ra, 0);
    wait_until(f + 520);
    check("R4 new start next frame", ma, 14'h200);
    wait_until(f + 520 + 160 + 3);
    check("R7 vsync black", colour_out, 0);
    wait_until(f + 520 + 320 + 3);
    check("R2 border at row R6", border, 1);

    write_reg(4'd6, 8'd0);
    cnt = 0;
    repeat (600) begin
      @(negedge clk);
      if (!border) cnt++;
    end
    check("R2 forced border R6=0", cnt, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end
endmodule